// File: doc/BRIEF.md
# Pilot Lock Qualifier and Second-Boundary Marker

This block sits next to a carrier tracking loop that follows a pilot tone. For every sample the loop hands over two things: the low-pass filtered in-phase level of the pilot, and a strobe that is high when the loop's phase accumulator has wrapped through a full turn. From these the block decides whether the loop holds a usable pilot, and it counts phase turns so it can mark the instant each second begins.

Lock is only declared once the in-phase level has stayed above a threshold for a configurable run of samples, so a short burst of pilot cannot produce a lock. Every second boundary seen while locked comes out as a one-cycle pulse together with a running pulse number and the absolute index of the sample at which it occurred. A single bad sample drops lock and restarts both the turn count and the pulse numbering. The sample index survives loss of lock. The threshold, the lock run length and the turns-per-second count are run-time inputs, and a configuration strobe restarts all counting.

Top module: `pilot_lock_pps`

## Requirements
- R1: A sample (a cycle with `smp_valid` high) is good when twice `inph_level` is strictly greater than `min_level`, both read as two's complement. On a good sample the lock run counter increments by one while it is below `lock_len` and otherwise holds.
- R2: A sample that is not good sets the lock run counter to zero.
- R3: `locked` is a registered flag that shows whether, after the most recent sample, the lock run counter is greater than or equal to `lock_len`. It reads 0 after reset.
- R4: Each sample with `wrap_strobe` high advances a turn counter by one. When the advanced value is greater than or equal to `turns_per_sec`, the counter returns to zero and that sample is a second boundary.
- R5: A second boundary on a sample after which the block is locked raises `pps_pulse` for exactly the following cycle. In that cycle `pps_index` shows the pulse number and `pps_sample` shows the sample index of that sample. The pulse number then increments by one.
- R6: After any sample at whose end the block is not locked, the turn counter and the pulse number are both zero. The first pulse after a regained lock is therefore numbered 0 and needs a full `turns_per_sec` turns counted while locked.
- R7: The 48-bit sample index starts at 0 for the first sample after reset or configuration and increments by one per sample. Loss of lock does not clear it.
- R8: In cycles with `smp_valid` low, `wrap_strobe`, `inph_level` and the configuration inputs have no effect: no pulse, no change of `locked`, and no counter advances.
- R9: A cycle with `cfg_load` high clears the lock run counter, the turn counter, the pulse number, the sample index and `locked`. A sample presented in that same cycle is discarded.
- R10: With `lock_len` equal to 0 the block is locked after every sample, good or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Restart all counting; overrides a sample in the same cycle |
| min_level | input | LVL_W+1 | Signed minimum-signal threshold compared against twice the level |
| lock_len | input | RUN_W | Number of good samples required before lock |
| turns_per_sec | input | TURN_W | Phase turns that make up one second |
| smp_valid | input | 1 | A new sample is present this cycle |
| inph_level | input | LVL_W | Signed filtered in-phase pilot level |
| wrap_strobe | input | 1 | The tracking loop phase wrapped on this sample |
| locked | output | 1 | Lock flag |
| pps_pulse | output | 1 | One-cycle second-boundary pulse |
| pps_index | output | 32 | Pulse number carried with the pulse, held until the next one |
| pps_sample | output | 48 | Sample index carried with the pulse, held until the next one |

## Verification
The bench walks the threshold edge where twice the level equals the threshold exactly: a design using greater-or-equal would keep lock there instead of dropping it. It breaks lock in the middle of a counted second and then checks that the first pulse after relock is numbered zero and arrives a full second of turns later. A design that kept the turn count or the pulse number across the loss would produce an early pulse or one with a carried-over number. It also drives wrap strobes on idle cycles, a configuration strobe together with a sample, a zero lock length with a negative threshold, and back-to-back boundaries with one turn per second. A wrong design would respectively count phantom turns, shift every later sample index, fail to lock, or drop consecutive pulses.

// File: rtl/plp_pkg.sv
package plp_pkg;

    localparam int SMP_W = 48;
    localparam int IDX_W = 32;

    typedef struct packed {
        logic             pulse;
        logic [IDX_W-1:0] idx_out;
        logic [SMP_W-1:0] at_out;
        logic [IDX_W-1:0] idx;
        logic [SMP_W-1:0] smp;
    } stamp_t;

endpackage

// File: rtl/plp_lock_ctr.sv
module plp_lock_ctr #(
    parameter int LVL_W = 16,
    parameter int RUN_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    smp_valid,
    input  logic signed [LVL_W-1:0] level,
    input  logic signed [LVL_W:0]   thresh,
    input  logic [RUN_W-1:0]        run_len,
    output logic                    locked_next,
    output logic                    locked_q
);

    localparam int CMP_W = LVL_W + 2;

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             locked;
    } lock_t;

    lock_t st_d, st_q;
    logic signed [CMP_W-1:0] twice_lvl;
    logic signed [CMP_W-1:0] thr_ext;
    logic                    good;

    always_comb begin
        twice_lvl = {level[LVL_W-1], level, 1'b0};
        thr_ext   = {thresh[LVL_W], thresh};
        good      = twice_lvl > thr_ext;
        st_d      = st_q;
        if (clear) begin
            st_d.run    = '0;
            st_d.locked = 1'b0;
        end else if (smp_valid) begin
            if (!good) begin
                st_d.run = '0;
            end else if (st_q.run < run_len) begin
                st_d.run = st_q.run + 1'b1;
            end
            st_d.locked = st_d.run >= run_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked_next = st_d.locked;
    assign locked_q    = st_q.locked;

endmodule

// File: rtl/plp_turn_div.sv
module plp_turn_div #(
    parameter int TURN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              smp_valid,
    input  logic              wrap,
    input  logic [TURN_W-1:0] limit,
    input  logic              keep,
    output logic              boundary
);

    typedef struct packed {
        logic [TURN_W-1:0] turns;
    } turn_t;

    turn_t           st_d, st_q;
    logic [TURN_W:0] advanced;
    logic            hit;

    always_comb begin
        st_d     = st_q;
        hit      = 1'b0;
        advanced = {1'b0, st_q.turns} + 1'b1;
        if (clear) begin
            st_d.turns = '0;
        end else if (smp_valid) begin
            if (wrap) begin
                if (advanced >= {1'b0, limit}) begin
                    st_d.turns = '0;
                    hit        = 1'b1;
                end else begin
                    st_d.turns = advanced[TURN_W-1:0];
                end
            end
            if (!keep) begin
                st_d.turns = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign boundary = hit && keep && !clear && smp_valid;

endmodule

// File: rtl/plp_stamp.sv
module plp_stamp
    import plp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             smp_valid,
    input  logic             fire,
    input  logic             keep,
    output logic             pulse,
    output logic [IDX_W-1:0] idx_out,
    output logic [SMP_W-1:0] at_out
);

    stamp_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (clear) begin
            st_d.idx = '0;
            st_d.smp = '0;
        end else if (smp_valid) begin
            if (fire) begin
                st_d.pulse   = 1'b1;
                st_d.idx_out = st_q.idx;
                st_d.at_out  = st_q.smp;
                st_d.idx     = st_q.idx + 1'b1;
            end
            if (!keep) begin
                st_d.idx = '0;
            end
            st_d.smp = st_q.smp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse   = st_q.pulse;
    assign idx_out = st_q.idx_out;
    assign at_out  = st_q.at_out;

endmodule

// File: rtl/pilot_lock_pps.sv
module pilot_lock_pps
    import plp_pkg::*;
#(
    parameter int LVL_W  = 16,
    parameter int RUN_W  = 16,
    parameter int TURN_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_load,
    input  logic signed [LVL_W:0]   min_level,
    input  logic [RUN_W-1:0]        lock_len,
    input  logic [TURN_W-1:0]       turns_per_sec,
    input  logic                    smp_valid,
    input  logic signed [LVL_W-1:0] inph_level,
    input  logic                    wrap_strobe,
    output logic                    locked,
    output logic                    pps_pulse,
    output logic [IDX_W-1:0]        pps_index,
    output logic [SMP_W-1:0]        pps_sample
);

    logic lock_after;
    logic second_hit;

    plp_lock_ctr #(
        .LVL_W (LVL_W),
        .RUN_W (RUN_W)
    ) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (cfg_load),
        .smp_valid   (smp_valid),
        .level       (inph_level),
        .thresh      (min_level),
        .run_len     (lock_len),
        .locked_next (lock_after),
        .locked_q    (locked)
    );

    plp_turn_div #(
        .TURN_W (TURN_W)
    ) u_turns (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cfg_load),
        .smp_valid (smp_valid),
        .wrap      (wrap_strobe),
        .limit     (turns_per_sec),
        .keep      (lock_after),
        .boundary  (second_hit)
    );

    plp_stamp u_stamp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cfg_load),
        .smp_valid (smp_valid),
        .fire      (second_hit),
        .keep      (lock_after),
        .pulse     (pps_pulse),
        .idx_out   (pps_index),
        .at_out    (pps_sample)
    );

endmodule

// File: rtl/plp_checker.sv
module plp_checker #(
    parameter int LVL_W = 16,
    parameter int RUN_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_load,
    input logic signed [LVL_W:0]   min_level,
    input logic [RUN_W-1:0]        lock_len,
    input logic                    smp_valid,
    input logic signed [LVL_W-1:0] inph_level,
    input logic                    locked,
    input logic                    pps_pulse,
    input logic [31:0]             pps_index,
    input logic [47:0]             pps_sample
);

    logic signed [LVL_W+1:0] dbl;
    logic signed [LVL_W+1:0] thr;
    logic                    sig_ok;

    always_comb begin
        dbl    = {inph_level[LVL_W-1], inph_level, 1'b0};
        thr    = {min_level[LVL_W], min_level};
        sig_ok = dbl > thr;
    end

    p_drop_on_bad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !cfg_load && !sig_ok && lock_len != '0) |=> !locked);

    p_pulse_while_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pps_pulse |-> locked);

    p_first_index_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pps_pulse && !$past(locked)) |-> pps_index == 32'd0);

    p_back_to_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pps_pulse && $past(pps_pulse)) |->
            (pps_sample == $past(pps_sample) + 48'd1 &&
             pps_index == $past(pps_index) + 32'd1));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !cfg_load) |=> (!pps_pulse && $stable(locked)));

    p_cfg_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (!locked && !pps_pulse));

    p_zero_len_locks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !cfg_load && lock_len == '0) |=> locked);

endmodule

bind pilot_lock_pps plp_checker #(
    .LVL_W (LVL_W),
    .RUN_W (RUN_W)
) u_plp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_load   (cfg_load),
    .min_level  (min_level),
    .lock_len   (lock_len),
    .smp_valid  (smp_valid),
    .inph_level (inph_level),
    .locked     (locked),
    .pps_pulse  (pps_pulse),
    .pps_index  (pps_index),
    .pps_sample (pps_sample)
);

// File: tb/tb_pilot_lock_pps.sv
module tb_pilot_lock_pps;

    localparam int LW = 16;
    localparam int RW = 16;
    localparam int TW = 16;

    typedef struct packed {
        logic [31:0] idx;
        logic [47:0] at;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cfg_load = 1'b0;
    logic signed [LW:0]   min_level = '0;
    logic [RW-1:0]        lock_len = '0;
    logic [TW-1:0]        turns_per_sec = '0;
    logic                 smp_valid = 1'b0;
    logic signed [LW-1:0] inph_level = '0;
    logic                 wrap_strobe = 1'b0;
    logic                 locked;
    logic                 pps_pulse;
    logic [31:0]          pps_index;
    logic [47:0]          pps_sample;

    int n_cmp = 0;
    int n_bad = 0;
    int n_seen = 0;
    exp_t expq[$];

    int          m_run = 0;
    int          m_turn = 0;
    logic [31:0] m_idx = 0;
    logic [47:0] m_smp = 0;
    bit          m_lock = 0;

    always #10 clk = ~clk;

    pilot_lock_pps #(.LVL_W(LW), .RUN_W(RW), .TURN_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .min_level(min_level),
        .lock_len(lock_len), .turns_per_sec(turns_per_sec), .smp_valid(smp_valid),
        .inph_level(inph_level), .wrap_strobe(wrap_strobe), .locked(locked),
        .pps_pulse(pps_pulse), .pps_index(pps_index), .pps_sample(pps_sample)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: applies one cycle, updates the reference, queues expected pulses
    task automatic step(input bit v, input int lvl, input bit w, input bit cfg, input string tag);
        bit good, hit;
        @(negedge clk);
        smp_valid   = v;
        inph_level  = LW'(lvl);
        wrap_strobe = w;
        cfg_load    = cfg;
        if (cfg) begin
            m_run = 0; m_turn = 0; m_idx = 0; m_smp = 0; m_lock = 0;
        end else if (v) begin
            good = (2 * lvl) > int'(min_level);
            if (!good) m_run = 0;
            else if (m_run < int'(lock_len)) m_run++;
            m_lock = m_run >= int'(lock_len);
            hit = 0;
            if (w) begin
                m_turn++;
                if (m_turn >= int'(turns_per_sec)) begin
                    m_turn = 0;
                    hit = 1;
                end
            end
            if (!m_lock) begin
                m_turn = 0;
                m_idx  = 0;
            end else if (hit) begin
                expq.push_back('{idx: m_idx, at: m_smp});
                m_idx++;
            end
            m_smp++;
        end
        @(posedge clk);
        #1;
        chk(locked == m_lock, tag, longint'(locked), longint'(m_lock));
        smp_valid = 1'b0;
        cfg_load  = 1'b0;
        wrap_strobe = 1'b0;
    endtask

    // monitor: every pulse must match the oldest queued expectation
    always @(negedge clk) begin
        if (rst_n && pps_pulse) begin
            n_seen++;
            if (expq.size() == 0) begin
                chk(1'b0, "R5 unexpected pulse", 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(pps_index == e.idx, "R5/R6 pulse number", longint'(pps_index), longint'(e.idx));
                chk(pps_sample == e.at, "R7 pulse sample index", longint'(pps_sample), longint'(e.at));
            end
        end
    end

    initial begin
        #(20 * 100000);
        chk(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(locked == 1'b0, "R3 reset lock", longint'(locked), 0);
        chk(pps_pulse == 1'b0, "R3 reset pulse", longint'(pps_pulse), 0);
        @(negedge clk);
        rst_n = 1'b1;

        min_level = 17'sd100; lock_len = 16'd5; turns_per_sec = 16'd3;
        // R9: sample together with configuration is discarded
        step(1, 51, 1, 1, "R9 cfg with sample");
        for (int i = 0; i < 4; i++) step(1, 51, 0, 0, "R1 below run length");
        step(1, 51, 0, 0, "R1 lock reached");
        chk(locked == 1'b1, "R1 locked after five good", longint'(locked), 1);
        // R2: equality with threshold is not good
        step(1, 50, 0, 0, "R2 equal threshold drops");
        chk(locked == 1'b0, "R2 unlocked", longint'(locked), 0);
        for (int i = 0; i < 30; i++) step(1, 60, (i % 2) == 1, 0, "R4 counting turns");
        // R8: idle cycles with strobes
        for (int i = 0; i < 3; i++) begin
            step(0, -500, 1, 0, "R8 idle");
            chk(pps_pulse == 1'b0, "R8 no pulse when idle", longint'(pps_pulse), 0);
        end
        for (int i = 0; i < 13; i++) step(1, 60, 1, 0, "R4 dense turns");
        // R6: loss of lock mid-second, then relock
        step(1, -3, 1, 0, "R6 lose lock");
        for (int i = 0; i < 20; i++) step(1, 70, 1, 0, "R6 relock");
        // R9 again, then zero run length with negative threshold
        step(1, 70, 1, 1, "R9 reconfigure");
        chk(locked == 1'b0, "R9 cleared lock", longint'(locked), 0);
        min_level = -17'sd10; lock_len = 16'd0; turns_per_sec = 16'd1;
        step(1, -4, 1, 0, "R10 locked at once");
        step(1, -5, 1, 0, "R10 bad sample keeps lock");
        chk(locked == 1'b1, "R10 lock held", longint'(locked), 1);
        for (int i = 0; i < 4; i++) step(1, -100, 1, 0, "R5 back to back");
        step(0, 0, 0, 0, "R8 drain");
        step(0, 0, 0, 0, "R8 drain");
        chk(expq.size() == 0, "R5 all expected pulses seen", longint'(expq.size()), 0);
        chk(n_seen > 8, "R4 pulse count", longint'(n_seen), 9);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule